// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block sits inside an SDRAM controller and owns the command pins and the clock-enable pin while the memory goes into self-refresh and while it comes back out. When the host controller asks the memory to sleep, the block can first run a full burst of back-to-back auto-refresh commands. It then issues the self-refresh entry command and holds the clock enable low. While the memory sleeps, all command pins show a deselect.

A wake request is recorded as soon as the sequence has left idle. It only takes effect once the memory has stayed in self-refresh for the minimum dwell time. Exit then waits for the host to report that the clock is running and stable. After that the block raises the clock enable, holds deselect through the exit window and the row-cycle recovery window, and can run a second full burst of auto-refreshes. Only then does it report the memory ready for normal commands.

All timing windows, the burst length and the choice of burst mode are parameters counted in clock cycles.

Top module: `srf_seq`

## Requirements
- R1: After reset the block is idle with `ready`=1, `cke`=1 and `cs_n`=1 (deselect); while `ready` is 1, `cke` and `cs_n` stay 1.
- R2: Self-refresh entry is the only cycle in which `cke` falls, and in that cycle `cs_n`=0, `ras_n`=0, `cas_n`=0 and `we_n`=1.
- R3: Once lowered, `cke` stays low for at least `T_RAS`+1 cycles (the entry cycle plus the `T_RAS` dwell), and until a wake request has been seen.
- R4: `cke` rises only in the cycle after one in which `clk_stable` was sampled 1. While `clk_stable` is 0, `cke` stays low.
- R5: Whenever `cke` is low, apart from the entry cycle, `cs_n` is 1. `cs_n` is also 1 in the cycle in which `cke` rises.
- R6: Counting the cycle in which `cke` rises as cycle 0, no command (`cs_n`=0) is issued and `ready` stays 0 before cycle `T_SRX`+`T_RC`.
- R7: With `BURST_EN`=1, exactly `BURST_LEN` auto-refresh commands (`cke`=1, `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1) are issued between the fall of `ready` and entry. The same number is issued between exit and the rise of `ready`. Consecutive refreshes are exactly `T_RC` cycles apart. With `BURST_EN`=0, no refresh is issued.
- R8: `ready` falls only in the cycle after `sleep_req` was sampled 1 in idle, and rises only when the whole exit sequence, including any post-exit burst, has finished.
- R9: `sleep_req` is ignored while not idle, and `wake_req` is ignored while idle: neither causes a further entry or leaves idle.
- R10: A `wake_req` pulse of one cycle, arriving at any point after the sleep request (during the pre-entry burst, the entry cycle or the dwell), is held. The memory then exits with no further wake request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to put the memory into self-refresh (sampled in idle) |
| wake_req | input | 1 | Request to bring the memory out of self-refresh (held once seen) |
| clk_stable | input | 1 | Memory clock is running and stable |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ready | output | 1 | Memory is available for normal commands |

## Verification
The capture of a wake request can fall in the same cycle as the issuing of a pre-entry burst refresh or of the entry command itself. The bench provokes this by pulsing `wake_req` for a single cycle as early as one cycle after `sleep_req`, and at random later points, on a burst and a non-burst instance driven side by side. It judges the outcome at the pins: the full refresh count must still precede entry, the dwell must still be respected, and the memory must come back out and raise `ready` with no second wake request.

// File: rtl/srf_pkg.sv
package srf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_BURST,
        ST_ENTER,
        ST_HOLD,
        ST_WAIT_CLK,
        ST_CKE_HIGH,
        ST_RECOVER,
        ST_POST_BURST
    } srf_state_e;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_pins_t;

    localparam sdr_pins_t PINS_DESEL_AWAKE = '{cke: 1'b1, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_pins_t PINS_DESEL_ASLEEP = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_pins_t PINS_AUTO_REF = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sdr_pins_t PINS_SELF_ENTRY = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic sdr_pins_t pins_for(input srf_state_e st, input logic fire_ref);
        sdr_pins_t p;
        unique case (st)
            ST_ENTER:                  p = PINS_SELF_ENTRY;
            ST_HOLD, ST_WAIT_CLK:      p = PINS_DESEL_ASLEEP;
            ST_PRE_BURST, ST_POST_BURST: p = fire_ref ? PINS_AUTO_REF : PINS_DESEL_AWAKE;
            default:                   p = PINS_DESEL_AWAKE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/srf_down_timer.sv
module srf_down_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/srf_burst_count.sv
module srf_burst_count #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == CW'(LIMIT));
endmodule

// File: rtl/srf_pin_encode.sv
module srf_pin_encode
    import srf_pkg::*;
(
    input  srf_state_e st,
    input  logic       fire_ref,
    output sdr_pins_t  pins
);
    always_comb pins = pins_for(st, fire_ref);
endmodule

// File: rtl/srf_seq.sv
module srf_seq
    import srf_pkg::*;
#(
    parameter int T_SRX     = 2,
    parameter int T_RC      = 9,
    parameter int T_RAS     = 7,
    parameter int BURST_LEN = 4096,
    parameter bit BURST_EN  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic clk_stable,
    output logic cke,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic ready
);
    localparam int TMAX = int'(max3(T_SRX, T_RC, T_RAS));
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] LD_RC  = TW'(T_RC - 1);
    localparam logic [TW-1:0] LD_RAS = TW'(T_RAS - 1);
    localparam logic [TW-1:0] LD_SRX = TW'(T_SRX - 1);

    srf_state_e st, st_nxt;
    logic       wake_pend;
    logic       t_load, t_zero;
    logic [TW-1:0] t_val;
    logic       b_clr, b_inc, b_done;
    logic       fire_ref;
    sdr_pins_t  pins;

    srf_down_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    generate
        if (BURST_EN) begin : g_burst
            srf_burst_count #(.LIMIT(BURST_LEN)) u_burst (
                .clk  (clk),
                .rst  (rst),
                .clr  (b_clr),
                .inc  (b_inc),
                .done (b_done)
            );
        end else begin : g_no_burst
            assign b_done = 1'b1;
        end
    endgenerate

    always_comb begin
        st_nxt   = st;
        t_load   = 1'b0;
        t_val    = '0;
        b_clr    = 1'b0;
        b_inc    = 1'b0;
        fire_ref = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (sleep_req) begin
                    if (BURST_EN) begin
                        st_nxt = ST_PRE_BURST;
                        t_load = 1'b1;
                        b_clr  = 1'b1;
                    end else begin
                        st_nxt = ST_ENTER;
                    end
                end
            end
            ST_PRE_BURST, ST_POST_BURST: begin
                if (t_zero) begin
                    if (b_done) begin
                        st_nxt = (st == ST_PRE_BURST) ? ST_ENTER : ST_IDLE;
                    end else begin
                        fire_ref = 1'b1;
                        b_inc    = 1'b1;
                        t_load   = 1'b1;
                        t_val    = LD_RC;
                    end
                end
            end
            ST_ENTER: begin
                st_nxt = ST_HOLD;
                t_load = 1'b1;
                t_val  = LD_RAS;
            end
            ST_HOLD: begin
                if (t_zero && (wake_pend || wake_req))
                    st_nxt = ST_WAIT_CLK;
            end
            ST_WAIT_CLK: begin
                if (clk_stable) begin
                    st_nxt = ST_CKE_HIGH;
                    t_load = 1'b1;
                    t_val  = LD_SRX;
                end
            end
            ST_CKE_HIGH: begin
                if (t_zero) begin
                    st_nxt = ST_RECOVER;
                    t_load = 1'b1;
                    t_val  = LD_RC;
                end
            end
            ST_RECOVER: begin
                if (t_zero) begin
                    if (BURST_EN) begin
                        st_nxt = ST_POST_BURST;
                        t_load = 1'b1;
                        b_clr  = 1'b1;
                    end else begin
                        st_nxt = ST_IDLE;
                    end
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            wake_pend <= 1'b0;
        end else begin
            st <= st_nxt;
            if (st_nxt == ST_WAIT_CLK)
                wake_pend <= 1'b0;
            else if (wake_req && (st == ST_PRE_BURST || st == ST_ENTER || st == ST_HOLD))
                wake_pend <= 1'b1;
        end
    end

    srf_pin_encode u_enc (
        .st       (st),
        .fire_ref (fire_ref),
        .pins     (pins)
    );

    assign cke   = pins.cke;
    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign ready = (st == ST_IDLE);
endmodule

// File: rtl/srf_seq_chk.sv
module srf_seq_chk #(
    parameter int T_SRX = 2,
    parameter int T_RC  = 9,
    parameter int T_RAS = 7
) (
    input logic clk,
    input logic rst,
    input logic clk_stable,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic ready
);
    localparam int LCAP = T_RAS + 1;
    localparam int XCAP = T_SRX + T_RC;
    localparam int LW   = $clog2(LCAP + 1);
    localparam int XW   = $clog2(XCAP + 1);
    localparam int GW   = $clog2(T_RC + 1);

    logic [LW-1:0] low_cnt;
    logic [XW-1:0] exit_cnt;
    logic [GW-1:0] ref_gap;
    logic          cke_d;
    logic          is_ref;

    assign is_ref = cke && !cs_n && !ras_n && !cas_n && we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            exit_cnt <= '0;
            ref_gap  <= GW'(T_RC);
            cke_d    <= 1'b1;
        end else begin
            cke_d <= cke;
            if (!cke)
                low_cnt <= (low_cnt < LW'(LCAP)) ? low_cnt + 1'b1 : low_cnt;
            else
                low_cnt <= '0;
            if (ready || !cke)
                exit_cnt <= '0;
            else if (!cke_d)
                exit_cnt <= XW'(1);
            else if (exit_cnt != '0 && exit_cnt < XW'(XCAP))
                exit_cnt <= exit_cnt + 1'b1;
            if (is_ref)
                ref_gap <= GW'(1);
            else if (ready)
                ref_gap <= GW'(T_RC);
            else if (ref_gap < GW'(T_RC))
                ref_gap <= ref_gap + 1'b1;
        end
    end

    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
        ready |-> (cke && cs_n));

    assert_entry_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> (!cs_n && !ras_n && !cas_n && we_n));

    assert_dwell_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> (low_cnt >= LW'(LCAP)));

    assert_clk_first_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> $past(clk_stable));

    assert_asleep_desel_R5: assert property (@(posedge clk) disable iff (rst)
        (!cke && !$fell(cke)) |-> cs_n);

    assert_rise_desel_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> cs_n);

    assert_recovery_R6: assert property (@(posedge clk) disable iff (rst)
        (cke && (!cs_n || ready) && exit_cnt != '0) |-> (exit_cnt >= XW'(XCAP)));

    assert_ref_gap_R7: assert property (@(posedge clk) disable iff (rst)
        is_ref |-> (ref_gap >= GW'(T_RC)));
endmodule

bind srf_seq srf_seq_chk #(
    .T_SRX (T_SRX),
    .T_RC  (T_RC),
    .T_RAS (T_RAS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_stable (clk_stable),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ready      (ready)
);

// File: tb/srf_seq_bench.sv
`timescale 1ns/1ps
module srf_seq_bench;
    localparam int P_SRX = 2;
    localparam int P_RC  = 3;
    localparam int P_RAS = 6;
    localparam int P_BL  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0;
    logic wake_req = 1'b0;
    logic clk_stable = 1'b1;

    logic cke_o [2];
    logic cs_o [2];
    logic ras_o [2];
    logic cas_o [2];
    logic we_o [2];
    logic rdy_o [2];

    int n_checks = 0;
    int n_err = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    srf_seq #(.T_SRX(P_SRX), .T_RC(P_RC), .T_RAS(P_RAS), .BURST_LEN(P_BL), .BURST_EN(1'b1)) u_srf_seq (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req), .clk_stable(clk_stable),
        .cke(cke_o[0]), .cs_n(cs_o[0]), .ras_n(ras_o[0]), .cas_n(cas_o[0]), .we_n(we_o[0]), .ready(rdy_o[0]));

    srf_seq #(.T_SRX(P_SRX), .T_RC(P_RC), .T_RAS(P_RAS), .BURST_LEN(P_BL), .BURST_EN(1'b0)) u_srf_seq_direct (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req), .clk_stable(clk_stable),
        .cke(cke_o[1]), .cs_n(cs_o[1]), .ras_n(ras_o[1]), .cas_n(cas_o[1]), .we_n(we_o[1]), .ready(rdy_o[1]));

    function automatic int exp_refs(input int inst);
        return (inst == 0) ? P_BL : 0;
    endfunction

    function automatic int min_low();
        return P_RAS + 1;
    endfunction

    function automatic int min_exit();
        return P_SRX + P_RC;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Pin monitor, sampled at the falling edge
    bit prev_cke [2] = '{1'b1, 1'b1};
    bit prev_rdy [2] = '{1'b1, 1'b1};
    bit in_exit [2] = '{1'b0, 1'b0};
    int low_cnt [2] = '{0, 0};
    int hi_cnt [2] = '{0, 0};
    int refs [2] = '{0, 0};
    int gap [2] = '{0, 0};
    bit prev_sleep = 1'b0;
    bit prev_stable = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 2; i++) begin
                bit is_ref;
                is_ref = cke_o[i] && !cs_o[i] && !ras_o[i] && !cas_o[i] && we_o[i];
                if (rdy_o[i] && !(cke_o[i] && cs_o[i]))
                    chk(1'b0, "R1", "idle pins cke&cs_n", {cke_o[i], cs_o[i]}, 3);
                if (prev_rdy[i] && !rdy_o[i]) begin
                    chk(prev_sleep, "R8", "ready fell without sleep_req", prev_sleep, 1);
                    refs[i] = 0;
                    gap[i] = 0;
                end
                if (is_ref) begin
                    refs[i]++;
                    if (gap[i] > 0)
                        chk(gap[i] == P_RC, "R7", "refresh spacing", gap[i], P_RC);
                    gap[i] = 1;
                end else if (gap[i] > 0) begin
                    gap[i]++;
                end
                if (prev_cke[i] && !cke_o[i]) begin
                    chk(!cs_o[i] && !ras_o[i] && !cas_o[i] && we_o[i], "R2", "entry command pins",
                        {cs_o[i], ras_o[i], cas_o[i], we_o[i]}, 1);
                    chk(refs[i] == exp_refs(i), "R7", "pre-entry refresh count", refs[i], exp_refs(i));
                    low_cnt[i] = 1;
                    refs[i] = 0;
                    gap[i] = 0;
                end else if (!cke_o[i]) begin
                    low_cnt[i]++;
                    if (!cs_o[i])
                        chk(1'b0, "R5", "cs_n while asleep", cs_o[i], 1);
                end
                if (!prev_cke[i] && cke_o[i]) begin
                    chk(low_cnt[i] >= min_low(), "R3", "cke low dwell", low_cnt[i], min_low());
                    chk(prev_stable, "R4", "clk_stable before cke rise", prev_stable, 1);
                    chk(cs_o[i], "R5", "cs_n at cke rise", cs_o[i], 1);
                    in_exit[i] = 1'b1;
                    hi_cnt[i] = 0;
                end else if (in_exit[i]) begin
                    hi_cnt[i]++;
                end
                if (in_exit[i] && (!cs_o[i] || rdy_o[i]))
                    chk(hi_cnt[i] >= min_exit(), "R6", "cycles from cke rise to command", hi_cnt[i], min_exit());
                if (!prev_rdy[i] && rdy_o[i]) begin
                    if (in_exit[i])
                        chk(refs[i] == exp_refs(i), "R7", "post-exit refresh count", refs[i], exp_refs(i));
                    else
                        chk(1'b0, "R8", "ready rose without exit", 0, 1);
                    in_exit[i] = 1'b0;
                    gap[i] = 0;
                end
                prev_cke[i] = cke_o[i];
                prev_rdy[i] = rdy_o[i];
            end
        end
        prev_sleep = sleep_req;
        prev_stable = clk_stable;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            chk(1'b0, "WDOG", "watchdog expired", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_req = 1'b1;
        step(1);
        wake_req = 1'b0;
    endtask

    task automatic wait_ready(input string req);
        int n;
        n = 0;
        while (!(rdy_o[0] && rdy_o[1]) && n < 3000) begin
            step(1);
            n++;
        end
        chk(rdy_o[0] && rdy_o[1], req, "return to ready", {rdy_o[0], rdy_o[1]}, 3);
        step(2);
    endtask

    task automatic scenario(input int d_wake, input int d_clk);
        clk_stable = 1'b0;
        pulse_sleep();
        step(d_wake - 1);
        pulse_wake();
        step(d_clk);
        clk_stable = 1'b1;
        wait_ready("R10");
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        step(3);
        // reset state
        @(negedge clk);
        chk(rdy_o[0] && rdy_o[1], "R1", "ready during reset", {rdy_o[0], rdy_o[1]}, 3);
        chk(cke_o[0] && cke_o[1] && cs_o[0] && cs_o[1], "R1", "cke/cs_n during reset",
            {cke_o[0], cke_o[1], cs_o[0], cs_o[1]}, 15);
        @(posedge clk);
        #1 rst = 1'b0;
        step(2);

        // wake while idle is ignored
        pulse_wake();
        step(5);
        @(negedge clk);
        chk(rdy_o[0] && rdy_o[1] && cke_o[0] && cke_o[1], "R9", "wake_req in idle ignored",
            {rdy_o[0], rdy_o[1], cke_o[0], cke_o[1]}, 15);
        step(1);

        // earliest wake: one cycle after sleep, lands during burst / entry
        scenario(1, 0);

        // wake right at entry of the direct instance, clock already stable
        clk_stable = 1'b1;
        pulse_sleep();
        pulse_wake();
        wait_ready("R10");

        // clock withheld: cke must stay low
        clk_stable = 1'b0;
        pulse_sleep();
        step(30);
        pulse_wake();
        step(30);
        @(negedge clk);
        chk(!cke_o[0] && !cke_o[1], "R4", "cke low while clock unstable", {cke_o[0], cke_o[1]}, 0);
        step(1);
        clk_stable = 1'b1;
        wait_ready("R4");

        // second sleep while asleep is ignored
        clk_stable = 1'b0;
        pulse_sleep();
        step(4);
        pulse_sleep();
        step(4);
        pulse_wake();
        clk_stable = 1'b1;
        wait_ready("R9");
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(rdy_o[0] && rdy_o[1], "R9", "no re-entry from stray sleep_req", {rdy_o[0], rdy_o[1]}, 3);
        end
        step(1);

        // random mix
        for (int k = 0; k < 25; k++) begin
            int dw;
            int dc;
            dw = 1 + int'($urandom_range(40));
            dc = int'($urandom_range(10));
            scenario(dw, dc);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule